// File: doc/BRIEF.md
# Selectable-Clock Serial Shift Interface

This block is a small serial port for a CPU. It holds an 8-bit shift register and a 4-bit event counter. Each clock event advances the counter. When the event is a shift event, the register moves its most significant bit out and takes the synchronized data line into its least significant bit. A 2-bit clock-select field picks where clock events come from: software strobe writes, a one-cycle compare-match pulse from an outside timer, or edges on the serial clock line. In the external modes the counter counts both edges of the line, and the register shifts on the rising or the falling edge only. In the external modes, software can also fake a line edge through a write with both strobe bits set.

A 2-bit wire-mode field changes only the outputs. The encodings are:
- 00: all outputs are quiet.
- 01: three-wire. The data-out and clock-out pins are driven.
- 10 and 11: two-wire. The block drives open-drain pull-low enables.

The clock and data inputs always work, whatever the mode. In two-wire mode a two-state bus monitor watches for start and stop conditions:
- BUS_FREE goes to BUS_ACTIVE on a start.
- BUS_ACTIVE goes to BUS_FREE on a stop, or when the mode leaves two-wire.
- A start seen in BUS_ACTIVE is a repeated start and keeps BUS_ACTIVE.

The monitor drives the start and stop flags. A collision bit lets software arbitrate for the bus. Two interrupt requests are gated by their enable bits and by a global enable.

The CPU reaches the block through a 2-bit-address register bus. Writes are synchronous and reads are combinational.
- Address 0 is the data register, which holds the shift register.
- Address 1 is the status register.
- Address 2 is the control register.
- Address 3 reads zero.

Top module: `shiftser_core`

## Requirements
- R1: The counter (status bits 3:0) advances by one for each clock event and holds otherwise. The clock-select field (control bits 3:2) picks the event source:
  - 00: a control write with bit 1 set.
  - 01: a timer_match pulse.
  - 10 and 11: every rising and every falling edge of the synchronized clock line.
- R2: On each shift event the data register (address 0) shifts left and takes the synchronized data line into bit 0. Shift events are:
  - clock-select 00 and 01: every clock event.
  - clock-select 10: a rising line edge.
  - clock-select 11: a falling line edge.
  A CPU write to address 0 loads the register.
- R3: The counter wraps from 15 to 0 on a clock event. The wrap sets the overflow flag (status bit 6). Writing status with bit 6 set clears that flag. A status write loads bits 3:0 into the counter, and this load takes priority over a clock event in the same cycle.
- R4: Writing control with bit 0 set toggles the clock-output level, which resets to 1. With clock-select 10 or 11, a write that also sets bit 1 counts as one line edge in the new level's direction, so it counts and may shift. A write with bit 0 alone only toggles.
- R5: In two-wire mode a falling data edge while the clock line is high is a start. It sets status bit 7 and moves the monitor to BUS_ACTIVE, so bus_busy is 1. A rising data edge while the clock line is high is a stop. It sets status bit 5 and moves the monitor to BUS_FREE. Writing one clears either flag. Neither condition is detected in other modes, and the stop flag raises no request.
- R6: Status bit 4 is 1 exactly when the mode is two-wire and data-register bit 7 differs from the synchronized data line.
- R7: irq_start_req equals start flag AND control bit 7 AND glob_ie. irq_ovf_req equals overflow flag AND control bit 6 AND glob_ie.
- R8: The wire-mode field (control bits 5:4) drives the outputs:
  - 00: tx_data_oe, tx_clk_oe, sda_pull_low and scl_pull_low are all 0.
  - 01: both output enables are 1; tx_data is data-register bit 7 and tx_clk is the clock-output level.
  - 10 and 11: sda_pull_low is NOT data-register bit 7, and scl_pull_low is NOT the clock-output level.
  The inputs still clock the counter in mode 00.
- R9: All registers reset to 0. Control reads back bits 7:2 as written, with bits 1:0 reading 0. Address 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| glob_ie | input | 1 | Global interrupt enable |
| timer_match | input | 1 | One-cycle compare-match pulse from a timer |
| line_clk_in | input | 1 | Serial clock line level |
| line_dat_in | input | 1 | Serial data line level |
| tx_data | output | 1 | Three-wire data output value |
| tx_data_oe | output | 1 | Three-wire data output enable |
| tx_clk | output | 1 | Three-wire clock output value |
| tx_clk_oe | output | 1 | Three-wire clock output enable |
| scl_pull_low | output | 1 | Two-wire clock open-drain pull-low enable |
| sda_pull_low | output | 1 | Two-wire data open-drain pull-low enable |
| bus_busy | output | 1 | Monitor is in BUS_ACTIVE |
| irq_start_req | output | 1 | Start-condition interrupt request |
| irq_ovf_req | output | 1 | Counter-overflow interrupt request |

## Verification
The bench builds the block with its default of two synchronizer stages. This makes every line change visible to the status register exactly three clocks later, so pin-driven checks can wait a fixed four cycles. The default 8-bit register and 4-bit counter put the 15-to-0 wrap within two timer pulses of a loaded value of 14. The 8-bit register also lets a short run of strobes produce shift patterns that can be told apart. Both interrupt gates, the faked line edges in both directions and the start and stop conditions are each driven in turn.

// File: rtl/shiftser_pkg.sv
package shiftser_pkg;
    localparam int DATA_W = 8;
    localparam int CNT_W  = 4;

    typedef enum logic [1:0] {
        ADR_DATA = 2'd0,
        ADR_STAT = 2'd1,
        ADR_CTRL = 2'd2,
        ADR_NONE = 2'd3
    } reg_addr_e;

    typedef enum logic [1:0] {
        WM_OFF      = 2'd0,
        WM_THREE    = 2'd1,
        WM_TWO      = 2'd2,
        WM_TWO_ALT  = 2'd3
    } wire_mode_e;

    typedef enum logic [1:0] {
        CS_SOFT     = 2'd0,
        CS_TIMER    = 2'd1,
        CS_EXT_RISE = 2'd2,
        CS_EXT_FALL = 2'd3
    } clk_sel_e;

    typedef enum logic {
        BUS_FREE   = 1'b0,
        BUS_ACTIVE = 1'b1
    } bus_state_e;

    typedef struct packed {
        logic       start_ie;
        logic       ovf_ie;
        wire_mode_e wmode;
        clk_sel_e   csel;
    } ctrl_t;
endpackage

// File: rtl/shiftser_linemon.sv
module shiftser_linemon
    import shiftser_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_line,
    input  logic dat_line,
    input  logic two_wire,
    output logic clk_lvl,
    output logic dat_lvl,
    output logic clk_rise,
    output logic clk_fall,
    output logic start_det,
    output logic stop_det,
    output logic busy
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] clk_sync, dat_sync;
    logic          clk_prev, dat_prev;
    logic          dat_rise, dat_fall;
    bus_state_e    state, state_nx;

    generate
        if (SYNC_STAGES > 1) begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    clk_sync <= '1;
                    dat_sync <= '1;
                end else begin
                    clk_sync <= {clk_sync[LAST-1:0], clk_line};
                    dat_sync <= {dat_sync[LAST-1:0], dat_line};
                end
            end
        end else begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    clk_sync <= '1;
                    dat_sync <= '1;
                end else begin
                    clk_sync <= clk_line;
                    dat_sync <= dat_line;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_prev <= 1'b1;
            dat_prev <= 1'b1;
        end else begin
            clk_prev <= clk_sync[LAST];
            dat_prev <= dat_sync[LAST];
        end
    end

    assign clk_lvl   = clk_sync[LAST];
    assign dat_lvl   = dat_sync[LAST];
    assign clk_rise  = clk_lvl & ~clk_prev;
    assign clk_fall  = ~clk_lvl & clk_prev;
    assign dat_rise  = dat_lvl & ~dat_prev;
    assign dat_fall  = ~dat_lvl & dat_prev;
    assign start_det = two_wire & dat_fall & clk_lvl;
    assign stop_det  = two_wire & dat_rise & clk_lvl;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= BUS_FREE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            BUS_FREE:   if (start_det) state_nx = BUS_ACTIVE;
            BUS_ACTIVE: if (stop_det || !two_wire) state_nx = BUS_FREE;
        endcase
    end

    // outputs
    always_comb begin
        busy = 1'b0;
        unique case (state)
            BUS_FREE:   busy = 1'b0;
            BUS_ACTIVE: busy = 1'b1;
        endcase
    end

    assert_start_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> busy);
    assert_stop_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !busy);
endmodule

// File: rtl/shiftser_clkgen.sv
module shiftser_clkgen
    import shiftser_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  clk_sel_e csel,
    input  logic     sw_clk,
    input  logic     sw_tog,
    input  logic     timer_match,
    input  logic     line_rise,
    input  logic     line_fall,
    output logic     cnt_evt,
    output logic     shift_evt,
    output logic     clk_out
);
    logic sw_edge, ext_rise, ext_fall;

    assign sw_edge  = sw_clk & sw_tog;
    assign ext_rise = line_rise | (sw_edge & ~clk_out);
    assign ext_fall = line_fall | (sw_edge & clk_out);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      clk_out <= 1'b1;
        else if (sw_tog) clk_out <= ~clk_out;
    end

    always_comb begin
        cnt_evt   = 1'b0;
        shift_evt = 1'b0;
        unique case (csel)
            CS_SOFT: begin
                cnt_evt   = sw_clk;
                shift_evt = sw_clk;
            end
            CS_TIMER: begin
                cnt_evt   = timer_match;
                shift_evt = timer_match;
            end
            CS_EXT_RISE: begin
                cnt_evt   = ext_rise | ext_fall;
                shift_evt = ext_rise;
            end
            CS_EXT_FALL: begin
                cnt_evt   = ext_rise | ext_fall;
                shift_evt = ext_fall;
            end
        endcase
    end

    assert_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sw_tog |=> (clk_out != $past(clk_out)));
    assert_shift_counts_R1: assert property (@(posedge clk) disable iff (!rst_n)
        shift_evt |-> cnt_evt);
endmodule

// File: rtl/shiftser_datapath.sv
module shiftser_datapath
    import shiftser_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_evt,
    input  logic              cnt_evt,
    input  logic              dat_lvl,
    input  logic              wr_data,
    input  logic              wr_stat,
    input  logic [DATA_W-1:0] wdata,
    input  logic              start_det,
    input  logic              stop_det,
    output logic [DATA_W-1:0] shreg,
    output logic [CNT_W-1:0]  cnt,
    output logic              start_flag,
    output logic              ovf_flag,
    output logic              stop_flag
);
    logic wrap;

    assign wrap = cnt_evt & ~wr_stat & (cnt == {CNT_W{1'b1}});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         shreg <= '0;
        else if (wr_data)   shreg <= wdata;
        else if (shift_evt) shreg <= {shreg[DATA_W-2:0], dat_lvl};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (wr_stat) cnt <= wdata[CNT_W-1:0];
        else if (cnt_evt) cnt <= cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_flag <= 1'b0;
            ovf_flag   <= 1'b0;
            stop_flag  <= 1'b0;
        end else begin
            if (wr_stat && wdata[7]) start_flag <= 1'b0;
            if (wr_stat && wdata[6]) ovf_flag   <= 1'b0;
            if (wr_stat && wdata[5]) stop_flag  <= 1'b0;
            if (start_det) start_flag <= 1'b1;
            if (wrap)      ovf_flag   <= 1'b1;
            if (stop_det)  stop_flag  <= 1'b1;
        end
    end

    assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_evt && !wr_stat) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));
    assert_count_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_evt && !wr_stat) |=> $stable(cnt));
    assert_wrap_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_evt && !wr_stat && cnt == {CNT_W{1'b1}}) |=> (ovf_flag && cnt == '0));
    assert_shift_in_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_evt && !wr_data) |=>
            (shreg[DATA_W-1:1] == $past(shreg[DATA_W-2:0]) && shreg[0] == $past(dat_lvl)));
endmodule

// File: rtl/shiftser_core.sv
module shiftser_core
    import shiftser_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] bus_addr,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       glob_ie,
    input  logic       timer_match,
    input  logic       line_clk_in,
    input  logic       line_dat_in,
    output logic       tx_data,
    output logic       tx_data_oe,
    output logic       tx_clk,
    output logic       tx_clk_oe,
    output logic       scl_pull_low,
    output logic       sda_pull_low,
    output logic       bus_busy,
    output logic       irq_start_req,
    output logic       irq_ovf_req
);
    ctrl_t             ctrl;
    reg_addr_e         addr;
    logic              wr_data, wr_stat, wr_ctrl;
    logic              two_wire, three_wire;
    logic              clk_lvl, dat_lvl, clk_rise, clk_fall;
    logic              start_det, stop_det;
    logic              cnt_evt, shift_evt, clk_out;
    logic [DATA_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt;
    logic              start_flag, ovf_flag, stop_flag, collision;

    assign addr    = reg_addr_e'(bus_addr);
    assign wr_data = bus_wr && (addr == ADR_DATA);
    assign wr_stat = bus_wr && (addr == ADR_STAT);
    assign wr_ctrl = bus_wr && (addr == ADR_CTRL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ctrl <= '0;
        else if (wr_ctrl) ctrl <= ctrl_t'(bus_wdata[7:2]);
    end

    assign two_wire   = (ctrl.wmode == WM_TWO) || (ctrl.wmode == WM_TWO_ALT);
    assign three_wire = (ctrl.wmode == WM_THREE);

    shiftser_linemon #(.SYNC_STAGES(SYNC_STAGES)) u_linemon (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_line  (line_clk_in),
        .dat_line  (line_dat_in),
        .two_wire  (two_wire),
        .clk_lvl   (clk_lvl),
        .dat_lvl   (dat_lvl),
        .clk_rise  (clk_rise),
        .clk_fall  (clk_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .busy      (bus_busy)
    );

    shiftser_clkgen u_clkgen (
        .clk         (clk),
        .rst_n       (rst_n),
        .csel        (ctrl.csel),
        .sw_clk      (wr_ctrl & bus_wdata[1]),
        .sw_tog      (wr_ctrl & bus_wdata[0]),
        .timer_match (timer_match),
        .line_rise   (clk_rise),
        .line_fall   (clk_fall),
        .cnt_evt     (cnt_evt),
        .shift_evt   (shift_evt),
        .clk_out     (clk_out)
    );

    shiftser_datapath u_datapath (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_evt  (shift_evt),
        .cnt_evt    (cnt_evt),
        .dat_lvl    (dat_lvl),
        .wr_data    (wr_data),
        .wr_stat    (wr_stat),
        .wdata      (bus_wdata),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .shreg      (shreg),
        .cnt        (cnt),
        .start_flag (start_flag),
        .ovf_flag   (ovf_flag),
        .stop_flag  (stop_flag)
    );

    assign collision = two_wire & (shreg[DATA_W-1] ^ dat_lvl);

    always_comb begin
        bus_rdata = '0;
        unique case (addr)
            ADR_DATA: bus_rdata = shreg;
            ADR_STAT: bus_rdata = {start_flag, ovf_flag, stop_flag, collision, cnt};
            ADR_CTRL: bus_rdata = {ctrl, 2'b00};
            ADR_NONE: bus_rdata = '0;
        endcase
    end

    assign tx_data      = shreg[DATA_W-1];
    assign tx_data_oe   = three_wire;
    assign tx_clk       = clk_out;
    assign tx_clk_oe    = three_wire;
    assign sda_pull_low = two_wire & ~shreg[DATA_W-1];
    assign scl_pull_low = two_wire & ~clk_out;

    assign irq_start_req = start_flag & ctrl.start_ie & glob_ie;
    assign irq_ovf_req   = ovf_flag & ctrl.ovf_ie & glob_ie;

    assert_off_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.wmode == WM_OFF) |-> !(tx_data_oe || tx_clk_oe || sda_pull_low || scl_pull_low));
    assert_irq_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_start_req || irq_ovf_req) |-> glob_ie);
    assert_ctrl_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> $stable(ctrl));
endmodule

// File: tb/tb_shiftser_core.sv
module tb_shiftser_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       glob_ie = 1'b0;
    logic       timer_match = 1'b0;
    logic       line_clk_in = 1'b1;
    logic       line_dat_in = 1'b1;
    logic       tx_data, tx_data_oe, tx_clk, tx_clk_oe;
    logic       scl_pull_low, sda_pull_low, bus_busy;
    logic       irq_start_req, irq_ovf_req;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    shiftser_core dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .glob_ie(glob_ie),
        .timer_match(timer_match), .line_clk_in(line_clk_in), .line_dat_in(line_dat_in),
        .tx_data(tx_data), .tx_data_oe(tx_data_oe), .tx_clk(tx_clk), .tx_clk_oe(tx_clk_oe),
        .scl_pull_low(scl_pull_low), .sda_pull_low(sda_pull_low), .bus_busy(bus_busy),
        .irq_start_req(irq_start_req), .irq_ovf_req(irq_ovf_req)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_timer();
        @(negedge clk); timer_match = 1'b1;
        @(negedge clk); timer_match = 1'b0;
    endtask

    task automatic test_reset();
        logic [7:0] v;
        rd(2'd0, v); chk("R9 data reset", v, 8'h00);
        rd(2'd1, v); chk("R9 status reset", v, 8'h00);
        rd(2'd2, v); chk("R9 control reset", v, 8'h00);
        chk("R8 outputs quiet at reset",
            {4'd0, tx_data_oe, tx_clk_oe, sda_pull_low, scl_pull_low}, 8'h00);
        chk("R7 no requests at reset", {6'd0, irq_start_req, irq_ovf_req}, 8'h00);
    endtask

    task automatic test_sw_clock();
        logic [7:0] v;
        wr(2'd2, 8'h00);
        wr(2'd0, 8'hA5);
        line_dat_in = 1'b1; settle();
        for (int i = 0; i < 3; i++) wr(2'd2, 8'h02);
        rd(2'd0, v); chk("R2 soft strobe shift", v, 8'h2F);
        rd(2'd1, v); chk("R1 soft strobe count", v, 8'h03);
    endtask

    task automatic test_timer();
        logic [7:0] v;
        wr(2'd2, 8'h04);
        wr(2'd1, 8'h00);
        line_dat_in = 1'b0; settle();
        for (int i = 0; i < 5; i++) pulse_timer();
        rd(2'd0, v); chk("R2 timer shift", v, 8'hE0);
        rd(2'd1, v); chk("R1 timer count", v, 8'h05);
    endtask

    task automatic test_overflow();
        logic [7:0] v;
        wr(2'd1, 8'h0E);
        pulse_timer(); pulse_timer();
        rd(2'd1, v); chk("R3 wrap sets overflow", v, 8'h40);
        wr(2'd2, 8'h44);
        @(negedge clk); glob_ie = 1'b0; #1;
        chk("R7 overflow gated by global", {7'd0, irq_ovf_req}, 8'h00);
        @(negedge clk); glob_ie = 1'b1; #1;
        chk("R7 overflow request", {7'd0, irq_ovf_req}, 8'h01);
        glob_ie = 1'b0;
        wr(2'd1, 8'h40);
        rd(2'd1, v); chk("R3 overflow write-one clear", v, 8'h00);
    endtask

    task automatic test_external();
        logic [7:0] v;
        wr(2'd2, 8'h08);
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h00);
        line_dat_in = 1'b1; settle();
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); line_clk_in = 1'b0; settle();
            @(negedge clk); line_clk_in = 1'b1; settle();
        end
        rd(2'd1, v); chk("R1 R8 both edges counted in mode off", v, 8'h08);
        rd(2'd0, v); chk("R2 rising-edge shift", v, 8'h0F);
    endtask

    task automatic test_sw_edge();
        logic [7:0] v;
        wr(2'd2, 8'h18);
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h00);
        chk("R8 three-wire enables", {6'd0, tx_data_oe, tx_clk_oe}, 8'h03);
        chk("R4 clock output reset level", {7'd0, tx_clk}, 8'h01);
        wr(2'd2, 8'h1B);
        rd(2'd1, v); chk("R4 faked falling edge counts", v, 8'h01);
        rd(2'd0, v); chk("R4 faked falling edge no shift", v, 8'h00);
        chk("R4 clock output low", {7'd0, tx_clk}, 8'h00);
        rd(2'd2, v); chk("R9 control readback", v, 8'h18);
        wr(2'd2, 8'h1B);
        rd(2'd1, v); chk("R4 faked rising edge counts", v, 8'h02);
        rd(2'd0, v); chk("R4 faked rising edge shifts", v, 8'h01);
        wr(2'd2, 8'h19);
        rd(2'd1, v); chk("R4 toggle alone no count", v, 8'h02);
        chk("R4 toggle alone flips clock", {7'd0, tx_clk}, 8'h00);
        wr(2'd2, 8'h19);
        chk("R8 tx_data follows bit 7", {7'd0, tx_data}, 8'h00);
    endtask

    task automatic test_two_wire();
        logic [7:0] v;
        line_clk_in = 1'b1; line_dat_in = 1'b1;
        wr(2'd2, 8'h20);
        wr(2'd0, 8'h80);
        settle();
        chk("R8 two-wire released", {6'd0, sda_pull_low, scl_pull_low}, 8'h00);
        rd(2'd1, v); chk("R6 no collision", v & 8'h10, 8'h00);
        @(negedge clk); line_dat_in = 1'b0; settle();
        rd(2'd1, v); chk("R5 R6 start and collision", v & 8'hF0, 8'h90);
        chk("R5 busy after start", {7'd0, bus_busy}, 8'h01);
        wr(2'd2, 8'hA0);
        glob_ie = 1'b1; #1;
        chk("R7 start request", {7'd0, irq_start_req}, 8'h01);
        @(negedge clk); line_dat_in = 1'b1; settle();
        rd(2'd1, v); chk("R5 stop flag", v & 8'hF0, 8'hA0);
        chk("R5 free after stop", {7'd0, bus_busy}, 8'h00);
        wr(2'd1, 8'hA0);
        rd(2'd1, v); chk("R5 flags cleared", v, 8'h00);
        chk("R5 stop raises no request", {6'd0, irq_start_req, irq_ovf_req}, 8'h00);
        glob_ie = 1'b0;
        wr(2'd0, 8'h00);
        chk("R8 data pull low", {7'd0, sda_pull_low}, 8'h01);
        wr(2'd0, 8'h80);
        wr(2'd2, 8'h00);
        @(negedge clk); line_dat_in = 1'b0; settle();
        rd(2'd1, v); chk("R5 R6 no start or collision in mode off", v, 8'h00);
        @(negedge clk); line_dat_in = 1'b1; settle();
        rd(2'd3, v); chk("R9 unused address", v, 8'h00);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog R1..all actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_sw_clock();
        test_timer();
        test_overflow();
        test_external();
        test_sw_edge();
        test_two_wire();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule